// File: doc/BRIEF.md
# Crate Energy Sum Trigger with Capture Window

This block forms a global energy sum once per sample period. Sixteen digitizer slots each present an unsigned energy value and a valid flag. A partial sum arriving from a neighbouring crate, with its own link-valid flag, is added to the slot values. The result saturates at the 32-bit ceiling. It is registered and driven out as a 32-bit sum word on every clock.

The same total is compared against a programmable threshold. A one-cycle trigger pulse is raised when the total first climbs strictly above it. Every total written while the block is armed also goes into a circular history memory. When a trigger arrives, the block collects a window of samples around it: 250 before the trigger sample, then the trigger sample and 249 after it. It then freezes the window until software-side logic has read it through an address/data port and released it.

Top module: `esum_trigger`

## Requirements
- R1: `sumOut` shows, one clock after the inputs are sampled, the sum of all valid slot values plus the remote sum when `remoteValid` is 1.
- R2: A slot whose `slotValid` bit is 0 adds zero, whatever its data. The remote value adds zero when `remoteValid` is 0.
- R3: A total that would exceed 2^32-1 appears as 32'hFFFF_FFFF on `sumOut` and does not wrap.
- R4: `trigOut` is high for exactly one cycle, in the same cycle as the first `sumOut` that is strictly greater than the threshold sampled with it. A total equal to the threshold does not trigger.
- R5: After a trigger, `trigOut` stays low until a total at or below the threshold has been seen. The next total above the threshold then triggers again.
- R6: A trigger seen while armed starts a capture. `capReady` rises 249 cycles after that `trigOut` pulse, once the trigger sample and 249 later samples are stored.
- R7: While `capReady` is 1, `rdData` shows, one cycle after `rdAddr` = k, the k-th oldest of the 500 captured totals. k = 0 is 250 samples before the trigger, and k = 250 is the trigger sample.
- R8: While `capReady` is 1, triggers are still produced on `trigOut`, but the captured window does not change.
- R9: Triggers that arrive while a capture is still collecting do not restart it. A `capRelease` pulse while `capReady` is 1 clears `capReady` on the next cycle and re-arms capture.
- R10: During reset, `sumOut` is 0, and `trigOut` and `capReady` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Active-low synchronous reset |
| slotSum | input | 256 | Slot energies, slot i in bits [16i+15:16i] |
| slotValid | input | 16 | Per-slot valid flags |
| remoteSum | input | 32 | Partial sum from another crate |
| remoteValid | input | 1 | Remote link valid |
| threshold | input | 32 | Trigger threshold (strict greater-than) |
| capRelease | input | 1 | Releases a frozen capture |
| rdAddr | input | 9 | Capture read index, 0..499 |
| sumOut | output | 32 | Registered saturated global sum |
| trigOut | output | 1 | One-cycle trigger pulse |
| capReady | output | 1 | Capture window frozen and readable |
| rdData | output | 32 | Captured total at `rdAddr`, one cycle later |

## Verification
A fault in the adder or the mask shows on `sumOut` in the very next cycle. A fault in the stored above-threshold flag shows as a missing or repeated `trigOut` pulse on the next threshold crossing. A write pointer or post-trigger counter that is off is visible only once the capture freezes. Then `capReady` rises on the wrong cycle, or a read sweep returns the window shifted or partly overwritten. For that reason, the bench compares every output on every cycle and sweeps the window after each capture.

// File: rtl/esum_pkg.sv
package esum_pkg;
  typedef enum logic [1:0] {
    CAP_ARMED  = 2'd0,
    CAP_POST   = 2'd1,
    CAP_FROZEN = 2'd2
  } capState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wrEn;  // store this sample's total in the history
  } dpCtrl_t;
endpackage

// File: rtl/esum_datapath.sv
module esum_datapath
  import esum_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int SLOT_W    = 16,
  parameter int SUM_W     = 32,
  parameter int DEPTH     = 500,
  localparam int ADDR_W   = $clog2(DEPTH)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_SLOTS*SLOT_W-1:0] slotSum,
  input  logic [NUM_SLOTS-1:0]        slotValid,
  input  logic [SUM_W-1:0]            remoteSum,
  input  logic                        remoteValid,
  input  logic [SUM_W-1:0]            threshold,
  input  dpCtrl_t                     ctrl,
  input  logic [ADDR_W-1:0]           rdAddr,
  output logic                        aboveNow,
  output logic [SUM_W-1:0]            sumOut,
  output logic [SUM_W-1:0]            rdData
);
  // one spare bit holds any carry past the ceiling; the local sum must fit SUM_W
  localparam int ACC_W = SUM_W + 1;
  localparam logic [SUM_W-1:0] SAT_MAX = {SUM_W{1'b1}};

  logic [SLOT_W-1:0] masked [NUM_SLOTS];
  logic [ACC_W-1:0]  acc;
  logic [SUM_W-1:0]  satTotal;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    assign masked[g] = slotValid[g] ? slotSum[g*SLOT_W +: SLOT_W] : '0;
  end

  always_comb begin
    acc = remoteValid ? {1'b0, remoteSum} : '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      acc = acc + ACC_W'(masked[i]);
    end
  end

  assign satTotal = acc[SUM_W] ? SAT_MAX : acc[SUM_W-1:0];
  assign aboveNow = satTotal > threshold;

  always_ff @(posedge clk) begin
    if (!rstN) sumOut <= '0;
    else       sumOut <= satTotal;
  end

  // circular history
  logic [SUM_W-1:0]  histMem [DEPTH];
  logic [ADDR_W-1:0] wrPtr;
  logic [ADDR_W:0]   rdSum;
  logic [ADDR_W:0]   rdWrap;
  logic [ADDR_W-1:0] rdIdx;

  always_ff @(posedge clk) begin
    if (ctrl.wrEn) histMem[wrPtr] <= satTotal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
    end else if (ctrl.wrEn) begin
      wrPtr <= (wrPtr == ADDR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
    end
  end

  // once frozen, wrPtr points at the oldest sample of the window
  always_comb begin
    rdSum  = {1'b0, wrPtr} + {1'b0, rdAddr};
    rdWrap = (rdSum >= (ADDR_W+1)'(DEPTH)) ? rdSum - (ADDR_W+1)'(DEPTH) : rdSum;
    rdIdx  = rdWrap[ADDR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else       rdData <= histMem[rdIdx];
  end
endmodule

// File: rtl/esum_control.sv
module esum_control
  import esum_pkg::*;
#(
  parameter int POST    = 250,
  localparam int CNT_W  = $clog2(POST + 1)
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    aboveNow,
  input  logic    capRelease,
  output dpCtrl_t ctrl,
  output logic    trigOut,
  output logic    capReady
);
  capState_e   state;
  logic        prevAbove;
  logic        trigNow;
  logic [CNT_W-1:0] postCnt;

  assign trigNow = aboveNow & ~prevAbove;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevAbove <= 1'b0;
      trigOut   <= 1'b0;
    end else begin
      prevAbove <= aboveNow;
      trigOut   <= trigNow;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= CAP_ARMED;
      postCnt <= '0;
    end else begin
      unique case (state)
        CAP_ARMED: begin
          if (trigNow) begin
            postCnt <= CNT_W'(1);
            state   <= (POST == 1) ? CAP_FROZEN : CAP_POST;
          end
        end
        CAP_POST: begin
          if (postCnt == CNT_W'(POST - 1)) state <= CAP_FROZEN;
          else                             postCnt <= postCnt + 1'b1;
        end
        CAP_FROZEN: begin
          if (capRelease) state <= CAP_ARMED;
        end
        default: state <= CAP_ARMED;
      endcase
    end
  end

  assign ctrl.wrEn = (state != CAP_FROZEN);
  assign capReady  = (state == CAP_FROZEN);
endmodule

// File: rtl/esum_trigger.sv
module esum_trigger
  import esum_pkg::*;
#(
  parameter int NUM_SLOTS    = 16,
  parameter int SLOT_W       = 16,
  parameter int SUM_W        = 32,
  parameter int PRE_SAMPLES  = 250,
  parameter int POST_SAMPLES = 250,
  localparam int DEPTH       = PRE_SAMPLES + POST_SAMPLES,
  localparam int ADDR_W      = $clog2(DEPTH)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_SLOTS*SLOT_W-1:0] slotSum,
  input  logic [NUM_SLOTS-1:0]        slotValid,
  input  logic [SUM_W-1:0]            remoteSum,
  input  logic                        remoteValid,
  input  logic [SUM_W-1:0]            threshold,
  input  logic                        capRelease,
  input  logic [ADDR_W-1:0]           rdAddr,
  output logic [SUM_W-1:0]            sumOut,
  output logic                        trigOut,
  output logic                        capReady,
  output logic [SUM_W-1:0]            rdData
);
  dpCtrl_t ctrl;
  logic    aboveNow;

  esum_datapath #(
    .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .SUM_W(SUM_W), .DEPTH(DEPTH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .slotSum(slotSum), .slotValid(slotValid),
    .remoteSum(remoteSum), .remoteValid(remoteValid), .threshold(threshold),
    .ctrl(ctrl), .rdAddr(rdAddr), .aboveNow(aboveNow),
    .sumOut(sumOut), .rdData(rdData)
  );

  esum_control #(.POST(POST_SAMPLES)) u_ctl (
    .clk(clk), .rstN(rstN), .aboveNow(aboveNow), .capRelease(capRelease),
    .ctrl(ctrl), .trigOut(trigOut), .capReady(capReady)
  );
endmodule

// File: rtl/esum_trigger_chk.sv
module esum_trigger_chk #(
  parameter int NUM_SLOTS = 16,
  parameter int SLOT_W    = 16,
  parameter int SUM_W     = 32,
  parameter int ADDR_W    = 9
) (
  input logic                        clk,
  input logic                        rstN,
  input logic [NUM_SLOTS*SLOT_W-1:0] slotSum,
  input logic [NUM_SLOTS-1:0]        slotValid,
  input logic [SUM_W-1:0]            remoteSum,
  input logic                        remoteValid,
  input logic [SUM_W-1:0]            threshold,
  input logic                        capRelease,
  input logic [ADDR_W-1:0]           rdAddr,
  input logic [SUM_W-1:0]            sumOut,
  input logic                        trigOut,
  input logic                        capReady,
  input logic [SUM_W-1:0]            rdData
);
  a_r2_all_masked_zero: assert property (@(posedge clk) disable iff (!rstN)
    (slotValid == '0 && !remoteValid) |=> (sumOut == '0));

  a_r3_saturate_at_ceiling: assert property (@(posedge clk) disable iff (!rstN)
    (remoteValid && remoteSum == '1) |=> (sumOut == '1));

  a_r4_trigger_above: assert property (@(posedge clk) disable iff (!rstN)
    trigOut |-> (sumOut > $past(threshold)));

  a_r5_no_back_to_back: assert property (@(posedge clk) disable iff (!rstN)
    trigOut |=> !trigOut);

  a_r8_frozen_holds: assert property (@(posedge clk) disable iff (!rstN)
    (capReady && !capRelease) |=> capReady);

  a_r9_release_clears: assert property (@(posedge clk) disable iff (!rstN)
    (capReady && capRelease) |=> !capReady);
endmodule

bind esum_trigger esum_trigger_chk #(
  .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .SUM_W(SUM_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rstN(rstN), .slotSum(slotSum), .slotValid(slotValid),
  .remoteSum(remoteSum), .remoteValid(remoteValid), .threshold(threshold),
  .capRelease(capRelease), .rdAddr(rdAddr), .sumOut(sumOut),
  .trigOut(trigOut), .capReady(capReady), .rdData(rdData)
);

// File: tb/esum_trigger_test.sv
module esum_trigger_test;
  localparam int NS = 16;
  localparam int SW = 16;
  localparam int POST = 250;
  localparam int DEPTH = 500;
  localparam longint unsigned CEIL = 64'hFFFF_FFFF;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [NS*SW-1:0] slotSum = '0;
  logic [NS-1:0]   slotValid = '0;
  logic [31:0]     remoteSum = '0;
  logic            remoteValid = 1'b0;
  logic [31:0]     threshold = '1;
  logic            capRelease = 1'b0;
  logic [8:0]      rdAddr = '0;
  logic [31:0]     sumOut;
  logic            trigOut;
  logic            capReady;
  logic [31:0]     rdData;

  esum_trigger uut (
    .clk(clk), .rstN(rstN), .slotSum(slotSum), .slotValid(slotValid),
    .remoteSum(remoteSum), .remoteValid(remoteValid), .threshold(threshold),
    .capRelease(capRelease), .rdAddr(rdAddr), .sumOut(sumOut),
    .trigOut(trigOut), .capReady(capReady), .rdData(rdData)
  );

  always #5 clk = ~clk;

  int vectors = 0;
  int misses = 0;
  bit finished = 0;

  // reference model state
  longint unsigned hist[$];
  longint unsigned win[DEPTH];
  bit mAbove = 0, mFrozen = 0, mPost = 0, prevFrozen = 0;
  int mCnt = 0;
  longint unsigned expSum = 0, expRd = 0;
  bit expTrig = 0, expCap = 0;
  string tagSum = "R1", tagTrig = "R4", tagCap = "R6";

  task automatic check(string tag, longint unsigned act, longint unsigned exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelEdge();
    longint unsigned t = 0;
    bit above;
    for (int i = 0; i < NS; i++) if (slotValid[i]) t += slotSum[i*SW +: SW];
    if (remoteValid) t += remoteSum;
    if (t > CEIL) t = CEIL;
    above = t > threshold;
    expSum = t;
    expTrig = above && !mAbove;
    mAbove = above;
    prevFrozen = mFrozen;
    if (mFrozen) begin
      expRd = win[rdAddr];
      if (capRelease) mFrozen = 0;
    end else begin
      hist.push_back(t);
      if (hist.size() > 1000) void'(hist.pop_front());
      if (mPost) begin
        mCnt++;
        if (mCnt == POST) begin
          mPost = 0;
          mFrozen = 1;
          for (int k = 0; k < DEPTH; k++) win[k] = hist[hist.size() - DEPTH + k];
        end
      end else if (expTrig) begin
        mPost = 1;
        mCnt = 1;
      end
    end
    expCap = mFrozen;
  endtask

  task automatic step();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    check(tagSum, sumOut, expSum);
    check(tagTrig, trigOut, expTrig);
    check(tagCap, capReady, expCap);
    if (prevFrozen) check("R7", rdData, expRd);
  endtask

  task automatic randSlots(bit allValid);
    for (int i = 0; i < NS; i++) slotSum[i*SW +: SW] = SW'($urandom);
    slotValid = allValid ? '1 : NS'($urandom);
    remoteSum = $urandom_range(0, 200000);
    remoteValid = allValid ? 1'b1 : 1'($urandom);
    rdAddr = 9'($urandom_range(0, DEPTH-1));
  endtask

  // total carried by the remote link; slot data present but masked off
  task automatic driveTotal(longint unsigned v, int n);
    for (int c = 0; c < n; c++) begin
      for (int i = 0; i < NS; i++) slotSum[i*SW +: SW] = SW'($urandom);
      slotValid = '0;
      remoteSum = 32'(v);
      remoteValid = 1'b1;
      step();
    end
  endtask

  task automatic sweep();
    for (int k = 0; k <= DEPTH; k++) begin
      rdAddr = 9'(k % DEPTH);
      step();
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", sumOut, 0);
    check("R10", trigOut, 0);
    check("R10", capReady, 0);
    rstN = 1'b1;

    // R1 all inputs valid, R2 random masking; threshold at ceiling blocks triggers
    tagSum = "R1";
    for (int c = 0; c < 150; c++) begin randSlots(1); step(); end
    tagSum = "R2";
    for (int c = 0; c < 160; c++) begin randSlots(0); step(); end

    // R3 saturation; R4 a total equal to the threshold does not fire
    tagSum = "R3";
    for (int c = 0; c < 20; c++) begin
      randSlots(1);
      remoteSum = 32'hFFFF_FF00;
      step();
    end
    tagSum = "R1";

    // R4/R5 edge qualification, R9 triggers during collection
    threshold = 32'd1000;
    tagTrig = "R5"; tagCap = "R9";
    driveTotal(500, 3);
    driveTotal(2000, 3);
    driveTotal(1000, 2);
    driveTotal(1001, 2);
    driveTotal(999, 1);
    driveTotal(1500, 2);
    for (int c = 0; c < 10; c++) begin driveTotal(0, 5); driveTotal(5000, 5); end
    tagCap = "R6";
    threshold = 32'd300000;
    for (int c = 0; c < 200; c++) begin randSlots(0); step(); end

    // R8: triggers while frozen leave the window untouched
    tagTrig = "R8"; tagCap = "R8";
    threshold = 32'd1000;
    for (int c = 0; c < 5; c++) begin driveTotal(0, 3); driveTotal(5000, 3); end
    driveTotal(0, 1);
    sweep();

    // R9 release and a second capture
    tagTrig = "R4"; tagCap = "R9";
    capRelease = 1'b1;
    driveTotal(0, 1);
    capRelease = 1'b0;
    tagCap = "R6";
    threshold = 32'd300000;
    for (int c = 0; c < 400; c++) begin randSlots(0); step(); end
    driveTotal(0, 1);
    sweep();

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      misses++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule